// File: doc/BRIEF.md
# Phase-Framed Video/Control Word Serializer

This block turns a parallel pixel stream into a single serial bit stream. Each pixel slot carries either an 18-bit video sample or a 9-bit control sample, and a data-enable input picks which. Every slot becomes one 20-bit word, shifted out least-significant bit first. Video words carry a type flag and an inversion flag. The inversion flag keeps a running disparity of ones against zeros close to zero. Control words carry a type flag. Five of the control bits are each sent three times, so the far end can take a majority vote on them. The other four control bits are each sent once.

Every change of data-enable is announced by a pair of fixed framing words. These words can never be mistaken for a data word. To make room for them, the data path runs two slots behind the inputs. Control samples that fall under a framing word are dropped. The block runs from a single bit clock. The pixel slot is 20 bit clocks long, and the block marks it with a strobe. Upstream logic presents a new sample in each strobe cycle.

Top module: `phase_word_serializer`

## Requirements
- R1: `pix_stb_o` is high for exactly one bit clock in every 20. After reset is released it first rises on the 20th bit clock. The inputs are sampled at the rising edge that ends the strobe cycle. That edge is step k, where k counts samples from 0.
- R2: A word loaded at a step appears on `ser_o` during the next 20 bit clocks, bit 0 first. Word bit i is on `ser_o` during the (i+1)-th bit clock after the load edge.
- R3: A video word has bit 0 = 1 and bit 1 = inversion flag. Bits 2..19 hold `vid_i[0..17]`, inverted bit-by-bit when the flag is 1.
- R4: A running disparity starts at 0 on reset. It adds (ones − zeros) of every video word sent, and only video words. If the running disparity is positive and the uninverted video word has more than 10 ones, the word is inverted. If it is negative and the uninverted word has fewer than 10 ones, the word is also inverted. Otherwise the word is sent uninverted.
- R5: The running disparity of sent video words never leaves the range −20..+20.
- R6: A control word has bit 0 = 0. Bits 3i+1..3i+3 each equal `ctl_i[i]` for i = 0..4. Bits 16..19 equal `ctl_i[5..8]`.
- R7: If `de_i` is low at sample j−1 and high at sample j, steps j and j+1 load 20'hAAAAA and then 20'hF0F0A. Step j+2 loads the video word of sample j.
- R8: If `de_i` is high at sample f−1 and low at sample f, steps f+2 and f+3 load 20'h0F0FA and then 20'h5555A. Step f+4 loads the control word of sample f+2.
- R9: Control values at samples j−2 and j−1 before a rise, during video samples, and at samples f and f+1 after a fall are never sent.
- R10: Apart from framing, the word loaded at step k is built from sample k−2. Before the first two samples after reset, that sample is taken as all zeros with data-enable low.
- R11: Each framing word has ten ones, bit 0 = 0 and bit 1 ≠ bit 2, so it matches no legal video or control word.
- R12: While `rst_n` is low, `ser_o` and `pix_stb_o` are 0. The words loaded at steps 0 and 1 after reset are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock, 20 per pixel slot |
| rst_n | input | 1 | Active-low synchronous reset |
| de_i | input | 1 | High selects video, low selects control |
| vid_i | input | 18 | Video sample |
| ctl_i | input | 9 | Control sample |
| ser_o | output | 1 | Serial word stream, LSB first |
| pix_stb_o | output | 1 | Sample strobe, one bit clock per slot |

## Verification
The framing assertions take two things for granted. First, every control phase between two video phases lasts at least four samples, so the exit pair and the entry pair never overlap. Second, the inputs hold steady through the strobe cycle. The stimulus table keeps every low stretch of data-enable at six samples or more. It changes the inputs only at the falling clock edge inside the strobe cycle. It places distinctive control values on the blackout slots, so any leak of them shows up as a word mismatch.

// File: rtl/pws_pkg.sv
`timescale 1ns/1ps
package pws_pkg;
    localparam int WORD_W      = 20;
    localparam int VID_W       = 18;
    localparam int CTL_W       = 9;
    localparam int REP_N       = 5;
    localparam int REP_K       = 3;
    localparam int SINGLE_BASE = 1 + REP_N * REP_K;
    localparam int HIST_N      = 5;
    localparam int PIPE_N      = 2;
    localparam int CNT_W       = $clog2(WORD_W);
    localparam int POP_W       = $clog2(WORD_W + 1);
    localparam int RD_W        = POP_W + 2;

    localparam logic [WORD_W-1:0] ENT_A  = 20'hAAAAA;
    localparam logic [WORD_W-1:0] ENT_B  = 20'hF0F0A;
    localparam logic [WORD_W-1:0] EXIT_A = 20'h0F0FA;
    localparam logic [WORD_W-1:0] EXIT_B = 20'h5555A;

    typedef struct packed {
        logic [HIST_N-2:0]             de_h;
        logic [PIPE_N-1:0][VID_W-1:0]  vid;
        logic [PIPE_N-1:0][CTL_W-1:0]  ctl;
        logic [RD_W-1:0]               rd;
    } fr_state_t;
endpackage

// File: rtl/pws_bit_timer.sv
`timescale 1ns/1ps
module pws_bit_timer
    import pws_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             step_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        step_o = (cnt_q == CNT_W'(WORD_W - 1));
        cnt_d  = step_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pws_word_builder.sv
`timescale 1ns/1ps
module pws_word_builder
    import pws_pkg::*;
(
    input  logic [HIST_N-1:0] de_hist_i,
    input  logic [VID_W-1:0]  vid_i,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [RD_W-1:0]   rd_i,
    output logic [WORD_W-1:0] word_o,
    output logic [RD_W-1:0]   rd_o
);
    localparam logic [POP_W-1:0] HALF = POP_W'(WORD_W / 2);

    logic [WORD_W-1:0] ctl_word, vid_plain, vid_flip;
    logic [POP_W-1:0]  pop_plain, pop_sent;
    logic              rd_pos, rd_neg, flip, is_vid;

    always_comb begin
        ctl_word = '0;
        for (int i = 0; i < REP_N; i++)
            ctl_word[1 + REP_K*i +: REP_K] = {REP_K{ctl_i[i]}};
        for (int i = 0; i < CTL_W - REP_N; i++)
            ctl_word[SINGLE_BASE + i] = ctl_i[REP_N + i];
    end

    always_comb begin
        vid_plain = {vid_i, 1'b0, 1'b1};
        vid_flip  = {~vid_i, 1'b1, 1'b1};
        pop_plain = POP_W'($countones(vid_plain));
        rd_neg    = rd_i[RD_W-1];
        rd_pos    = !rd_neg && (rd_i != '0);
        flip      = (rd_pos && pop_plain > HALF) || (rd_neg && pop_plain < HALF);
    end

    always_comb begin
        is_vid = 1'b0;
        if (de_hist_i[2]) begin
            is_vid = 1'b1;
            word_o = flip ? vid_flip : vid_plain;
        end else if (de_hist_i[3]) begin
            word_o = EXIT_A;
        end else if (de_hist_i[4]) begin
            word_o = EXIT_B;
        end else if (de_hist_i[1]) begin
            word_o = ENT_B;
        end else if (de_hist_i[0]) begin
            word_o = ENT_A;
        end else begin
            word_o = ctl_word;
        end
    end

    always_comb begin
        pop_sent = POP_W'($countones(word_o));
        rd_o     = is_vid ? rd_i + ((RD_W'(pop_sent) - RD_W'(HALF)) << 1) : rd_i;
    end
endmodule

// File: rtl/pws_shifter.sv
`timescale 1ns/1ps
module pws_shifter
    import pws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] sh_o,
    output logic              ser_o
);
    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = load_i ? word_i : {1'b0, sh_q[WORD_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sh_o  = sh_q;
    assign ser_o = sh_q[0];
endmodule

// File: rtl/phase_word_serializer.sv
`timescale 1ns/1ps
module phase_word_serializer
    import pws_pkg::*;
(
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic             de_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic [CTL_W-1:0] ctl_i,
    output logic             ser_o,
    output logic             pix_stb_o
);
    fr_state_t         st_d, st_q;
    logic              step;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] word, sh;
    logic [RD_W-1:0]   rd_nxt, rd_q;
    logic [HIST_N-1:0] de_hist;
    logic [VID_W-1:0]  vid_m;
    logic [CTL_W-1:0]  ctl_m;

    assign de_hist = {st_q.de_h, de_i};
    assign vid_m   = st_q.vid[PIPE_N-1];
    assign ctl_m   = st_q.ctl[PIPE_N-1];
    assign rd_q    = st_q.rd;

    pws_bit_timer u_timer (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .cnt_o  (cnt),
        .step_o (step)
    );

    pws_word_builder u_build (
        .de_hist_i (de_hist),
        .vid_i     (vid_m),
        .ctl_i     (ctl_m),
        .rd_i      (rd_q),
        .word_o    (word),
        .rd_o      (rd_nxt)
    );

    pws_shifter u_shift (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .load_i (step),
        .word_i (word),
        .sh_o   (sh),
        .ser_o  (ser_o)
    );

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.de_h = {st_q.de_h[HIST_N-3:0], de_i};
            st_d.vid  = {st_q.vid[PIPE_N-2:0], vid_i};
            st_d.ctl  = {st_q.ctl[PIPE_N-2:0], ctl_i};
            st_d.rd   = rd_nxt;
        end
    end

    always_ff @(posedge clk_bit) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_stb_o = step;
endmodule

// File: rtl/pws_checker.sv
`timescale 1ns/1ps
module pws_checker
    import pws_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic [CNT_W-1:0]  cnt,
    input logic [WORD_W-1:0] sh,
    input logic [WORD_W-1:0] word,
    input logic [HIST_N-1:0] dh,
    input logic [VID_W-1:0]  vid_m,
    input logic [CTL_W-1:0]  ctl_m,
    input logic [RD_W-1:0]   rd
);
    localparam logic [RD_W-1:0] RD_LIM = RD_W'(WORD_W);

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);                                                  // R1
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WORD_W - 1));                                       // R1
    AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> (sh == ($past(sh) >> 1)));                              // R2
    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (sh == $past(word)));                                    // R2
    AST_VIDEO_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dh[2]) |-> (word[0] &&
            word[WORD_W-1:2] == (word[1] ? ~vid_m : vid_m)));              // R3
    AST_INV_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dh[2] && !rd[RD_W-1] && rd != '0) |->
            ($countones(word) <= WORD_W/2));                              // R4
    AST_INV_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dh[2] && rd[RD_W-1]) |->
            ($countones(word) >= WORD_W/2));                              // R4
    AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(rd) <= $signed(RD_LIM)) && ($signed(rd) >= -$signed(RD_LIM))); // R5
    AST_CTRL_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dh == '0) |-> (!word[0] &&
            word[3:1] == {3{ctl_m[0]}} && word[15:13] == {3{ctl_m[4]}} &&
            word[19:16] == ctl_m[8:5]));                                  // R6
    AST_ENTRY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dh == 5'b00001) |-> (word == ENT_A));                    // R7
    AST_EXIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dh[3] && !dh[2]) |-> (word == EXIT_A));                  // R8
endmodule

bind phase_word_serializer pws_checker u_pws_chk (
    .clk   (clk_bit),
    .rst_n (rst_n),
    .step  (step),
    .cnt   (cnt),
    .sh    (sh),
    .word  (word),
    .dh    (de_hist),
    .vid_m (vid_m),
    .ctl_m (ctl_m),
    .rd    (rd_q)
);

// File: tb/phase_word_serializer_bench.sv
`timescale 1ns/1ps
module phase_word_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        de_i = 1'b0;
    logic [17:0] vid_i = '0;
    logic [8:0]  ctl_i = '0;
    logic        ser_o, pix_stb_o;

    int n_chk = 0, n_fail = 0, nsamp = 0, rd_m = 0, rx_rd = 0;
    bit done = 0;
    logic        s_de  [0:63];
    logic [17:0] s_vid [0:63];
    logic [8:0]  s_ctl [0:63];

    localparam int NS = 28;
    localparam logic [27:0] STIM [NS] = '{
        {1'b0, 18'h00000, 9'h0A5}, {1'b0, 18'h00000, 9'h15A},
        {1'b0, 18'h00000, 9'h1FF}, {1'b0, 18'h00000, 9'h1FF},
        {1'b1, 18'h3FFFF, 9'h1C3}, {1'b1, 18'h3FFFF, 9'h0F0},
        {1'b1, 18'h00000, 9'h111}, {1'b1, 18'h00000, 9'h1FF},
        {1'b1, 18'h2AAAA, 9'h1FF}, {1'b1, 18'h3F000, 9'h1FF},
        {1'b0, 18'h15555, 9'h1FF}, {1'b0, 18'h00000, 9'h1FF},
        {1'b0, 18'h00000, 9'h0C3}, {1'b0, 18'h00000, 9'h13C},
        {1'b0, 18'h00000, 9'h1FF}, {1'b0, 18'h00000, 9'h1FF},
        {1'b1, 18'h3FFFE, 9'h1FF}, {1'b1, 18'h3FFFC, 9'h1FF},
        {1'b1, 18'h0001F, 9'h1FF}, {1'b0, 18'h00000, 9'h1FF},
        {1'b0, 18'h00000, 9'h1FF}, {1'b0, 18'h00000, 9'h001},
        {1'b0, 18'h00000, 9'h100}, {1'b0, 18'h00000, 9'h0AA},
        {1'b0, 18'h00000, 9'h155}, {1'b0, 18'h00000, 9'h1FF},
        {1'b0, 18'h00000, 9'h1FF}, {1'b1, 18'h12345, 9'h1FF}
    };

    phase_word_serializer u_phase_word_serializer (
        .clk_bit   (clk),
        .rst_n     (rst_n),
        .de_i      (de_i),
        .vid_i     (vid_i),
        .ctl_i     (ctl_i),
        .ser_o     (ser_o),
        .pix_stb_o (pix_stb_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic de_at(input int i);
        return (i < 0) ? 1'b0 : s_de[i];
    endfunction
    function automatic logic [17:0] vid_at(input int i);
        return (i < 0) ? 18'h0 : s_vid[i];
    endfunction
    function automatic logic [8:0] ctl_at(input int i);
        return (i < 0) ? 9'h0 : s_ctl[i];
    endfunction

    function automatic logic [19:0] ctl_layout(input logic [8:0] c);
        logic [19:0] w;
        w = '0;
        for (int b = 1; b < 20; b++)
            w[b] = (b <= 15) ? c[(b - 1) / 3] : c[b - 11];
        return w;
    endfunction

    // entered at a falling edge inside a strobe cycle
    task automatic do_step(input logic de, input logic [17:0] vid, input logic [8:0] ctl);
        logic [19:0] exp, rx;
        string tag;
        bit stb_bad, framing, video;
        int k, ones;
        k = nsamp;
        de_i = de; vid_i = vid; ctl_i = ctl;
        s_de[k] = de; s_vid[k] = vid; s_ctl[k] = ctl;
        framing = 1'b1; video = 1'b0;
        if (de_at(k - 2)) begin
            video = 1'b1; framing = 1'b0; tag = "R3 R4";
            exp = {vid_at(k - 2), 2'b01};
            ones = $countones(exp);
            if ((rd_m > 0 && ones > 10) || (rd_m < 0 && ones < 10))
                exp = {~vid_at(k - 2), 2'b11};
            rd_m += 2 * $countones(exp) - 20;
        end else if (de_at(k - 3)) begin
            exp = 20'h0F0FA; tag = "R8 R9";
        end else if (de_at(k - 4)) begin
            exp = 20'h5555A; tag = "R8 R9";
        end else if (de_at(k - 1)) begin
            exp = 20'hF0F0A; tag = "R7 R9";
        end else if (de_at(k)) begin
            exp = 20'hAAAAA; tag = "R7 R9";
        end else begin
            exp = ctl_layout(ctl_at(k - 2)); tag = "R6"; framing = 1'b0;
        end
        stb_bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rx[i] = ser_o;
            if ((i == 19) != pix_stb_o) stb_bad = 1'b1;
        end
        check(rx == exp, {tag, " R2 R10 word"}, 32'(rx), 32'(exp));
        check(!stb_bad, "R1 strobe period", 32'(stb_bad), 32'd0);
        if (framing)
            check($countones(rx) == 10 && !rx[0] && rx[1] != rx[2],
                  "R11 framing word form", 32'(rx), 32'(exp));
        if (video) begin
            rx_rd += 2 * $countones(rx) - 20;
            check(rx_rd <= 20 && rx_rd >= -20, "R5 disparity bound",
                  32'(rx_rd), 32'd20);
        end
        nsamp++;
    endtask

    task automatic release_and_sync();
        int n;
        bit low_ok;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0; low_ok = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (!pix_stb_o && ser_o) low_ok = 1'b0;
        end while (!pix_stb_o && n < 100);
        check(n == 19, "R1 first strobe after reset", 32'(n), 32'd19);
        check(low_ok, "R12 serial idle after reset", 32'(low_ok), 32'd1);
        nsamp = 0; rd_m = 0; rx_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!ser_o && !pix_stb_o, "R12 outputs in reset",
              32'({ser_o, pix_stb_o}), 32'd0);
        release_and_sync();

        for (int t = 0; t < NS; t++)
            do_step(STIM[t][27], STIM[t][26:9], STIM[t][8:0]);
        for (int t = 0; t < 4; t++)
            do_step(1'b0, 18'h0, 9'h000);

        // directed: reset in the middle of a video phase
        do_step(1'b1, 18'h2F0F0, 9'h0);
        do_step(1'b1, 18'h2F0F0, 9'h0);
        do_step(1'b1, 18'h00FFF, 9'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check(!ser_o && !pix_stb_o, "R12 outputs forced low by reset",
              32'({ser_o, pix_stb_o}), 32'd0);
        repeat (3) @(negedge clk);
        de_i = 1'b0; vid_i = '0; ctl_i = '0;
        release_and_sync();
        // first two words after reset are zero, then the first control sample
        do_step(1'b0, 18'h3FFFF, 9'h155);
        do_step(1'b0, 18'h0, 9'h0F0);
        do_step(1'b0, 18'h0, 9'h0);
        do_step(1'b0, 18'h0, 9'h0);
        // back-to-back full-ones video exercises the inversion path
        do_step(1'b0, 18'h0, 9'h0);
        do_step(1'b1, 18'h3FFFF, 9'h0);
        do_step(1'b1, 18'h3FFFF, 9'h0);
        do_step(1'b1, 18'h3FFFF, 9'h0);
        do_step(1'b1, 18'h00000, 9'h0);
        do_step(1'b0, 18'h0, 9'h0);
        do_step(1'b0, 18'h0, 9'h0);
        do_step(1'b0, 18'h0, 9'h0);
        do_step(1'b0, 18'h0, 9'h0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule